// File: doc/BRIEF.md
# Four-Output Signal Steering Unit

This block sends one data signal to any combination of four output pins. Each pin has a steering bit. When the bit is set, the pin carries the data signal, and a per-pin polarity bit can invert it. When the bit is clear, the pin holds a fixed level that comes from a per-pin override bit. A shutdown input moves every steered pin to its own safe level and leaves the override pins alone.

New steering settings arrive as a write strobe with a data word. The mode input decides when a write takes effect:
- In immediate mode the write takes effect on the clock that accepts it. A pulse on a pin may then be cut short.
- In edge-aligned mode the written value waits in a shadow register. It takes effect on the next rising edge of the data signal, so every waveform on a pin is complete.

The data signal may be asynchronous to the block clock. It passes through a flop synchronizer before edges are detected. All pin outputs are registered.

Top module: `steer_unit`

## Requirements
- R1: While reset is asserted and on the first clock after it, every pin output is 0, the active steering word is 0 and the shadow word is 0.
- R2: A pin whose active steering bit is 0 drives its override bit. Its polarity bit and the shutdown input have no effect on that pin.
- R3: A pin whose active steering bit is 1 follows `data_in` with three clocks of latency: two synchronizer stages and one output register.
- R4: A steered pin whose polarity bit is 1 outputs the inverse of the synchronized data. A polarity bit of 0 passes the data unchanged.
- R5: Any subset of the four pins may be steered at the same time, from none to all four. All steered pins carry the same data. Bit i of every per-pin word belongs to pin i.
- R6: When `mode` is 3'b000 (immediate), a write with `steer_we` = 1 loads `steer_wdata` into the active steering word on that clock. The pin outputs reflect the new word on the same clock edge.
- R7: When `mode` is 3'b001 (edge-aligned), the active steering word changes only on a clock where a rising edge of the synchronized data is detected, that is, where it is 1 now and was 0 one clock earlier. On that clock it takes the pending value.
- R8: In edge-aligned mode, a write on the same clock as a detected rising edge is applied on that edge. A later write before the next edge replaces the pending value. The shadow word updates on every write, whatever the mode.
- R9: While `shdn` is 1, every steered pin drives its bit of `shdn_lvl`. Polarity is not applied to that level.
- R10: On the first clock after `shdn` returns to 0, steered pins again follow the data signal with their polarity applied.
- R11: Only bit 0 of `mode` selects the mode: 0 is immediate and 1 is edge-aligned. Bits 2:1 have no effect, so 3'b101 behaves as 3'b001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| data_in | input | 1 | Data signal to steer; may be asynchronous |
| mode | input | 3 | Bit 0: 0 immediate, 1 edge-aligned |
| steer_we | input | 1 | Write strobe for a new steering word |
| steer_wdata | input | 4 | New steering word, bit i for pin i |
| pol | input | 4 | Per-pin inversion for steered pins |
| ovr | input | 4 | Per-pin fixed level for unsteered pins |
| shdn | input | 1 | Shutdown request |
| shdn_lvl | input | 4 | Per-pin level for steered pins during shutdown |
| pin_out | output | 4 | Registered pin outputs |

## Verification
The bench builds the unit with its default parameters: four pins and two synchronizer stages. This makes every subset of pins reachable, along with the exact three-clock path from the data input to the pins. The clock-level reference model therefore covers these cases:
- writes that land on the same clock as a detected rising edge;
- writes that land between edges;
- repeated writes that overwrite a pending word;
- shutdown applied over a mix of steered and override pins.

// File: rtl/steer_pkg.sv
package steer_pkg;

    typedef enum logic [2:0] {
        STEER_IMMEDIATE = 3'b000,
        STEER_ON_EDGE   = 3'b001
    } steer_mode_e;

    function automatic logic mode_is_sync(input logic [2:0] m);
        return m[0];
    endfunction

endpackage

// File: rtl/steer_sync.sv
module steer_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic data_in,
    output logic data_s,
    output logic rise
);
    localparam int CHAIN_W = STAGES + 1;

    typedef struct packed {
        logic [CHAIN_W-1:0] chain;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[CHAIN_W-2:0], data_in};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign data_s = st_q.chain[STAGES-1];
    assign rise   = st_q.chain[STAGES-1] & ~st_q.chain[STAGES];

    // An edge needs a low sample before it, so two edges cannot be back to back.
    p_rise_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

endmodule

// File: rtl/steer_shadow.sv
module steer_shadow #(
    parameter int NUM_PINS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sync_mode,
    input  logic                rise,
    input  logic                we,
    input  logic [NUM_PINS-1:0] wdata,
    output logic [NUM_PINS-1:0] act_d_o,
    output logic [NUM_PINS-1:0] act_q_o
);
    typedef struct packed {
        logic [NUM_PINS-1:0] act;
        logic [NUM_PINS-1:0] shd;
    } shadow_state_t;

    shadow_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) st_d.shd = wdata;
        if (sync_mode) begin
            if (rise) st_d.act = we ? wdata : st_q.shd;
        end else if (we) begin
            st_d.act = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign act_d_o = st_d.act;
    assign act_q_o = st_q.act;

    p_async_apply_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_mode && we) |=> (st_q.act == $past(wdata)));

    p_sync_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_mode && !rise) |=> $stable(st_q.act));

    p_pend_apply_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_mode && rise && !we) |=> (st_q.act == $past(st_q.shd)));

endmodule

// File: rtl/steer_pin.sv
module steer_pin (
    input  logic clk,
    input  logic rst_n,
    input  logic steer,
    input  logic data,
    input  logic pol,
    input  logic ovr,
    input  logic shdn,
    input  logic lvl,
    output logic pin_q_o
);
    typedef struct packed {
        logic pin;
    } pin_state_t;

    pin_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!steer)    st_d.pin = ovr;
        else if (shdn) st_d.pin = lvl;
        else           st_d.pin = data ^ pol;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pin_q_o = st_q.pin;

    p_ovr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(steer)) |-> (st_q.pin == $past(ovr)));

    p_shdn_lvl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(steer) && $past(shdn)) |-> (st_q.pin == $past(lvl)));

    p_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(steer) && !$past(shdn)) |-> (st_q.pin == ($past(data) ^ $past(pol))));

endmodule

// File: rtl/steer_unit.sv
module steer_unit #(
    parameter int NUM_PINS    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                data_in,
    input  logic [2:0]          mode,
    input  logic                steer_we,
    input  logic [NUM_PINS-1:0] steer_wdata,
    input  logic [NUM_PINS-1:0] pol,
    input  logic [NUM_PINS-1:0] ovr,
    input  logic                shdn,
    input  logic [NUM_PINS-1:0] shdn_lvl,
    output logic [NUM_PINS-1:0] pin_out
);
    import steer_pkg::*;

    logic                data_s;
    logic                rise;
    logic                sync_mode;
    logic [NUM_PINS-1:0] act_d;
    logic [NUM_PINS-1:0] act_q;

    assign sync_mode = mode_is_sync(mode);

    steer_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .data_in (data_in),
        .data_s  (data_s),
        .rise    (rise)
    );

    steer_shadow #(.NUM_PINS(NUM_PINS)) u_shadow (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_mode (sync_mode),
        .rise      (rise),
        .we        (steer_we),
        .wdata     (steer_wdata),
        .act_d_o   (act_d),
        .act_q_o   (act_q)
    );

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        steer_pin u_pin (
            .clk     (clk),
            .rst_n   (rst_n),
            .steer   (act_d[i]),
            .data    (data_s),
            .pol     (pol[i]),
            .ovr     (ovr[i]),
            .shdn    (shdn),
            .lvl     (shdn_lvl[i]),
            .pin_q_o (pin_out[i])
        );
    end

    // Pins that are not steered ignore shutdown.
    p_shdn_scope_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(shdn)) |-> ((pin_out & ~act_q) == ($past(ovr) & ~act_q)));

endmodule

// File: tb/tb_steer_unit.sv
module tb_steer_unit;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         data_in = 1'b0;
    logic [2:0]   mode = 3'b000;
    logic         steer_we = 1'b0;
    logic [N-1:0] steer_wdata = '0;
    logic [N-1:0] pol = '0;
    logic [N-1:0] ovr = '0;
    logic         shdn = 1'b0;
    logic [N-1:0] shdn_lvl = '0;
    logic [N-1:0] pin_out;

    int    checks = 0;
    int    failures = 0;
    string tag = "R1";
    bit    finished = 1'b0;

    // Data generator settings.
    bit gen_en = 1'b0;
    int half = 3;
    int gcnt = 0;

    // Reference model state.
    bit         hq[$];
    logic [N-1:0] m_act, m_shd, m_out;

    always #4 clk = ~clk;

    steer_unit dut (
        .clk(clk), .rst_n(rst_n), .data_in(data_in), .mode(mode),
        .steer_we(steer_we), .steer_wdata(steer_wdata), .pol(pol), .ovr(ovr),
        .shdn(shdn), .shdn_lvl(shdn_lvl), .pin_out(pin_out)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            hq = {1'b0, 1'b0, 1'b0};
            m_act = '0; m_shd = '0; m_out = '0;
        end else begin
            bit ds, rs;
            logic [N-1:0] nact;
            ds = hq[1];
            rs = hq[1] && !hq[2];
            nact = m_act;
            if (mode[0]) begin
                if (rs) nact = steer_we ? steer_wdata : m_shd;
            end else if (steer_we) begin
                nact = steer_wdata;
            end
            if (steer_we) m_shd = steer_wdata;
            for (int i = 0; i < N; i++)
                m_out[i] = nact[i] ? (shdn ? shdn_lvl[i] : (ds ^ pol[i])) : ovr[i];
            m_act = nact;
            hq.push_front(data_in);
            void'(hq.pop_back());
        end
    end

    task automatic check(input logic [N-1:0] act, input logic [N-1:0] exp, input string r);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: pin_out=%b expected=%b at %0t", r, act, exp, $time);
        end
    endtask

    // Compare against the model on every clock, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !finished) check(pin_out, m_out, tag);
        if (gen_en) begin
            gcnt++;
            if (gcnt >= half) begin gcnt = 0; data_in <= ~data_in; end
        end
    end

    task automatic wr(input logic [N-1:0] v);
        @(negedge clk);
        steer_we = 1'b1; steer_wdata = v;
        @(negedge clk);
        steer_we = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(8 * 150000);
        failures++;
        $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        idle(3);
        check(pin_out, '0, "R1");
        rst_n = 1'b1;
        @(negedge clk);
        check(pin_out, '0, "R1");

        // Override levels only, with shutdown and polarity that must not matter.
        tag = "R2";
        ovr = 4'b1010; pol = 4'b1111; idle(3);
        check(pin_out, 4'b1010, "R2");
        shdn = 1'b1; shdn_lvl = 4'b0101; idle(3);
        check(pin_out, 4'b1010, "R2");
        shdn = 1'b0; pol = '0; ovr = 4'b0101; idle(3);

        // Steered data and the three-clock latency.
        tag = "R3";
        wr(4'b0001);
        @(negedge clk); data_in = 1'b1;
        idle(2);
        check(pin_out[0], 1'b0, "R3");
        idle(1);
        check(pin_out[0], 1'b1, "R3");
        data_in = 1'b0; idle(4);

        tag = "R6";
        gen_en = 1'b1; half = 5;
        idle(12); wr(4'b1111); idle(7); wr(4'b0000); idle(13);
        tag = "R5";
        wr(4'b1111); idle(20); wr(4'b1001); idle(20);
        tag = "R4";
        pol = 4'b0110; wr(4'b0110); idle(25); pol = 4'b1010; wr(4'b1111); idle(25);

        // Edge-aligned mode.
        tag = "R7";
        mode = 3'b001; pol = '0;
        wr(4'b0011); idle(30); wr(4'b1100); idle(30);
        tag = "R8";
        wr(4'b0001); wr(4'b1110); idle(25);
        half = 3;
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            steer_we = ($urandom % 4) == 0;
            steer_wdata = 4'($urandom);
        end
        steer_we = 1'b0;

        // Shutdown and recovery.
        tag = "R9";
        mode = 3'b000; ovr = 4'b1010; pol = 4'b0100;
        wr(4'b0101); idle(8);
        shdn = 1'b1; shdn_lvl = 4'b0011; idle(3);
        check(pin_out, 4'b1011, "R9");
        idle(10);
        tag = "R10";
        shdn = 1'b0; idle(20);

        tag = "R11";
        mode = 3'b101; wr(4'b1111); idle(30);
        mode = 3'b110; wr(4'b0010); idle(20);

        tag = "R8";
        for (int k = 0; k < 600; k++) begin
            @(negedge clk);
            if ((k % 100) == 0) mode = 3'($urandom);
            steer_we = ($urandom % 3) == 0;
            steer_wdata = 4'($urandom);
            pol = 4'($urandom); ovr = 4'($urandom);
            shdn = ($urandom % 8) == 0; shdn_lvl = 4'($urandom);
            half = 1 + ($urandom % 4);
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule